// File: doc/BRIEF.md
# Two-Channel Serial Audio Port

This block connects a two-channel PCM stream on a three-wire serial link (bit clock, channel clock, data) to a parallel sample interface. The receive side turns the serial data into one left word and one right word. Each word is placed at the top of a `WORD_W`-bit sample. When a full left-and-right pair has arrived, the block raises a one-cycle strobe. The transmit side takes a parallel pair at the start of each frame and shifts it out. Its data changes only after a falling bit-clock edge, and each word is placed in its slot according to the selected output format.

Four control inputs set the operation: the frame mode, the input word format, the output word format and the channel-clock polarity. In the three external modes, the bit clock and channel clock come from outside the block. They are passed straight through to the output pins and sampled into the system clock domain. In the internal mode, the block makes its own 64-bit-per-frame timing by dividing the system clock, and both the receiver and the transmitter use that timing. The serial clocks must be much slower than the system clock: each bit-clock phase must last at least four system-clock cycles.

Top module: `serial_audio_port`

## Requirements
- R1: With `in_fmt` 00, 01 or 10, the received word is the last 16, 18 or 20 bits, MSB first, captured on rising bit-clock edges just before the channel clock changes. It is stored MSB-aligned in the `WORD_W` sample, with zeros in the unused low bits.
- R2: With `in_fmt` 11 at 64 bit clocks per frame (`sync_mode` 00 or 11), the received word is 20 bits long and its MSB is the second bit of the channel slot.
- R3: With `sync_mode` 01 (32 bit clocks per frame), every input format is received as 16-bit right-justified. With `sync_mode` 10 (48 per frame), `in_fmt` 11 is received as 20-bit right-justified.
- R4: A channel slot carries left data when the channel clock equals `left_is_high`; otherwise it carries right data. This applies to both directions.
- R5: `rx_valid` is high for exactly one cycle, on the first rising bit clock of the left slot that follows a complete left-then-right pair. `rx_left` and `rx_right` change only in that cycle. `rx_valid` never shares a cycle with `tx_load`.
- R6: When `out_fmt[1]` is 0, the transmitted word is right-justified: 16 bits (`out_fmt[0]`=0) or 20 bits (`out_fmt[0]`=1) taken from the top of the sample, MSB first. Its last bit falls on the last bit of the slot, and every other slot bit is 0.
- R7: When `out_fmt[1]` is 1, the transmitted word starts with its MSB on the second bit of the slot. Every other slot bit is 0.
- R8: With `sync_mode` 01, a 20-bit output format is sent as 16 bits.
- R9: `tx_load` pulses for one cycle at the falling bit clock that starts a left slot. At that edge the block captures `tx_left` and `tx_right`, and sends them during that frame.
- R10: `sd_out` changes only after a falling bit-clock edge, while the bit clock is low.
- R11: With `sync_mode` other than 00, `bck_out` and `lrck_out` follow `bck_in` and `lrck_in` directly. Slots are 16, 24 or 32 bits long for modes 01, 10 and 11.
- R12: With `sync_mode` 00, `bck_out` has a period of 2×`HALF_DIV` system clocks and each channel-clock level lasts 32 bit clocks. The channel clock changes together with a falling bit clock, and the left slot comes first after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_mode | input | 2 | 00 internal timing (64/frame), 01/10/11 external timing with 32/48/64 bit clocks per frame |
| in_fmt | input | 2 | Receive format: 00 RJ16, 01 RJ18, 10 RJ20, 11 I2S-style 20 |
| out_fmt | input | 2 | Transmit format: bit 1 I2S-style, bit 0 20-bit word |
| left_is_high | input | 1 | Channel-clock level that marks the left slot |
| bck_in | input | 1 | External bit clock |
| lrck_in | input | 1 | External channel clock |
| sd_in | input | 1 | Serial receive data |
| tx_left | input | WORD_W | Left sample to transmit |
| tx_right | input | WORD_W | Right sample to transmit |
| bck_out | output | 1 | Bit clock toward the link |
| lrck_out | output | 1 | Channel clock toward the link |
| sd_out | output | 1 | Serial transmit data |
| tx_load | output | 1 | Strobe: transmit pair captured |
| rx_left | output | WORD_W | Last received left sample |
| rx_right | output | WORD_W | Last received right sample |
| rx_valid | output | 1 | Strobe: new received pair |

## Verification
The bound checker watches four things on every cycle. It checks that both strobes are single-cycle pulses and never coincide, and that the received words stay put between strobes. It checks that transmit data moves only in the low phase of the bit clock. In internal mode it checks that the generated bit clock never toggles on two adjacent cycles. Only the bench scenarios can show that data lands in the right place: the bit position of each format, the way format codes are cut back when a frame is too short, the polarity choice, the pass-through of external clocks, and the divider period and slot length of internal timing. The bench checks these by driving full frames and by looping the transmitter back into the receiver.

// File: rtl/sap_pkg.sv
package sap_pkg;

   // resolved word layout for one direction
   typedef struct packed {
      logic       i2s;
      logic [4:0] len;
   } fmt_t;

   function automatic logic [5:0] slot_bits(input logic [1:0] mode);
      case (mode)
         2'b01:   return 6'd16;
         2'b10:   return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

   function automatic fmt_t rx_fmt(input logic [1:0] mode, input logic [1:0] code);
      fmt_t r;
      r.i2s = 1'b0;
      r.len = 5'd16;
      if (mode != 2'b01) begin
         case (code)
            2'b00:   r.len = 5'd16;
            2'b01:   r.len = 5'd18;
            2'b10:   r.len = 5'd20;
            default: begin
               r.len = 5'd20;
               r.i2s = (mode == 2'b00) || (mode == 2'b11);
            end
         endcase
      end
      return r;
   endfunction

   function automatic fmt_t tx_fmt(input logic [1:0] mode, input logic [1:0] code);
      fmt_t r;
      r.i2s = code[1];
      r.len = (code[0] && mode != 2'b01) ? 5'd20 : 5'd16;
      return r;
   endfunction

endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic left_is_high,
   output logic bck,
   output logic lrck
);
   localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HALF_DIV - 1);

   logic [HW-1:0] hcnt;
   logic [5:0]    bitn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt <= '0;
         bck  <= 1'b0;
         bitn <= '0;
      end else if (!en) begin
         hcnt <= '0;
         bck  <= 1'b0;
         bitn <= '0;
      end else if (hcnt == HLAST) begin
         hcnt <= '0;
         bck  <= ~bck;
         if (bck) bitn <= bitn + 6'd1;
      end else begin
         hcnt <= hcnt + HW'(1);
      end
   end

   // first half of the 64-bit frame is the left slot
   assign lrck = left_is_high ^ bitn[5];

endmodule

// File: rtl/sap_rx.sv
module sap_rx
   import sap_pkg::*;
#(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              is_left,
   input  logic              sd,
   input  fmt_t              fmt,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid
);
   logic [31:0]       sreg;
   logic [31:0]       masked;
   logic              primed, prev_left, have_left;
   logic [WORD_W-1:0] hold_l, word;

   always_comb begin
      masked = sreg & ((32'd1 << fmt.len) - 32'd1);
      if (fmt.i2s) word = WORD_W'(32'(sreg[30:11]) << (WORD_W - 20));
      else         word = WORD_W'(masked << (WORD_W - int'(fmt.len)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '0;
         primed    <= 1'b0;
         prev_left <= 1'b0;
         have_left <= 1'b0;
         hold_l    <= '0;
         rx_left   <= '0;
         rx_right  <= '0;
         rx_valid  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (rise) begin
            sreg      <= {sreg[30:0], sd};
            primed    <= 1'b1;
            prev_left <= is_left;
            if (primed && is_left != prev_left) begin
               if (prev_left) begin
                  hold_l    <= word;
                  have_left <= 1'b1;
               end else if (have_left) begin
                  rx_left   <= hold_l;
                  rx_right  <= word;
                  rx_valid  <= 1'b1;
                  have_left <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/sap_tx.sv
module sap_tx
   import sap_pkg::*;
#(
   parameter int WORD_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              is_left,
   input  fmt_t              fmt,
   input  logic [5:0]        slot_p,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   output logic              sd_out,
   output logic              tx_load
);
   logic              primed, last_left, new_slot, bit_n;
   logic [5:0]        pos, pos_n;
   logic [WORD_W-1:0] buf_l, buf_r, word, sh;
   int                first;

   always_comb begin
      new_slot = fall && primed && (is_left != last_left);
      pos_n    = new_slot ? 6'd0 : ((pos == 6'd63) ? pos : pos + 6'd1);
      word     = (new_slot && is_left) ? tx_left : (is_left ? buf_l : buf_r);
      first    = fmt.i2s ? 1 : int'(slot_p) - int'(fmt.len);
      sh       = '0;
      bit_n    = 1'b0;
      if (int'(pos_n) >= first && int'(pos_n) < first + int'(fmt.len)) begin
         sh    = word >> (WORD_W - 1 - (int'(pos_n) - first));
         bit_n = sh[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed    <= 1'b0;
         last_left <= 1'b0;
         pos       <= '0;
         sd_out    <= 1'b0;
         buf_l     <= '0;
         buf_r     <= '0;
         tx_load   <= 1'b0;
      end else begin
         tx_load <= 1'b0;
         if (rise || fall) begin
            primed    <= 1'b1;
            last_left <= is_left;
         end
         if (fall && primed) begin
            pos    <= pos_n;
            sd_out <= bit_n;
            if (new_slot && is_left) begin
               buf_l   <= tx_left;
               buf_r   <= tx_right;
               tx_load <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
   import sap_pkg::*;
#(
   parameter int WORD_W      = 20,
   parameter int HALF_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sync_mode,
   input  logic [1:0]        in_fmt,
   input  logic [1:0]        out_fmt,
   input  logic              left_is_high,
   input  logic              bck_in,
   input  logic              lrck_in,
   input  logic              sd_in,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   output logic              bck_out,
   output logic              lrck_out,
   output logic              sd_out,
   output logic              tx_load,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid
);
   if (WORD_W < 20 || WORD_W > 32) begin : g_bad_width
      $error("WORD_W must lie in 20..32");
   end
   if (HALF_DIV < 2) begin : g_bad_div
      $error("HALF_DIV must be at least 2");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 2) begin : g_bad_sync
      $error("SYNC_STAGES must be 1 or 2");
   end

   logic [2:0] syn;
   logic       gen_bck, gen_lr, use_int;
   logic       src_bck, src_lr, bck_d, rise, fall, is_left;
   fmt_t       rfmt, tfmt;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) syn <= '0;
         else        syn <= {bck_in, lrck_in, sd_in};
   end else begin : g_sync2
      logic [2:0] s1;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            s1  <= '0;
            syn <= '0;
         end else begin
            s1  <= {bck_in, lrck_in, sd_in};
            syn <= s1;
         end
   end

   assign use_int = (sync_mode == 2'b00);

   sap_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
      .clk(clk), .rst_n(rst_n), .en(use_int), .left_is_high(left_is_high),
      .bck(gen_bck), .lrck(gen_lr)
   );

   assign src_bck  = use_int ? gen_bck : syn[2];
   assign src_lr   = use_int ? gen_lr  : syn[1];
   assign bck_out  = use_int ? gen_bck : bck_in;
   assign lrck_out = use_int ? gen_lr  : lrck_in;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) bck_d <= 1'b0;
      else        bck_d <= src_bck;

   assign rise    = src_bck & ~bck_d;
   assign fall    = ~src_bck & bck_d;
   assign is_left = (src_lr == left_is_high);
   assign rfmt    = rx_fmt(sync_mode, in_fmt);
   assign tfmt    = tx_fmt(sync_mode, out_fmt);

   sap_rx #(.WORD_W(WORD_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .is_left(is_left), .sd(syn[0]),
      .fmt(rfmt), .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
   );

   sap_tx #(.WORD_W(WORD_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .is_left(is_left),
      .fmt(tfmt), .slot_p(slot_bits(sync_mode)), .tx_left(tx_left),
      .tx_right(tx_right), .sd_out(sd_out), .tx_load(tx_load)
   );

endmodule

// File: rtl/serial_audio_port_chk.sv
module serial_audio_port_chk #(
   parameter int WORD_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        sync_mode,
   input logic              bck_out,
   input logic              sd_out,
   input logic              rx_valid,
   input logic              tx_load,
   input logic [WORD_W-1:0] rx_left,
   input logic [WORD_W-1:0] rx_right
);
   // R5
   rx_strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R5
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_left) && $stable(rx_right)));

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_valid, tx_load}));

   // R9
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);

   // R10
   sd_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_out != $past(sd_out)) |-> !$past(bck_out));

   // R12
   int_bck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode == 2'b00 && $past(sync_mode) == 2'b00 && bck_out != $past(bck_out))
      |=> $stable(bck_out));

endmodule

bind serial_audio_port serial_audio_port_chk #(.WORD_W(WORD_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .bck_out(bck_out),
   .sd_out(sd_out), .rx_valid(rx_valid), .tx_load(tx_load),
   .rx_left(rx_left), .rx_right(rx_right)
);

// File: tb/test_serial_audio_port.sv
module test_serial_audio_port;
   typedef struct packed {
      logic [1:0]  m;
      logic [1:0]  fi;
      logic [1:0]  fo;
      logic        pol;
      logic [19:0] il;
      logic [19:0] ir;
      logic [19:0] tl;
      logic [19:0] tr;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{2'b11, 2'b00, 2'b00, 1'b1, 20'h0BEEF, 20'h01234, 20'hF00D5, 20'h3A5A5},
      '{2'b11, 2'b01, 2'b01, 1'b0, 20'h2ACE1, 20'h15F0F, 20'h9C3E7, 20'h6B1D2},
      '{2'b11, 2'b10, 2'b10, 1'b1, 20'hC3A5E, 20'h7E81B, 20'hABCDE, 20'h13579},
      '{2'b11, 2'b11, 2'b11, 1'b0, 20'h8F0E1, 20'hD2468, 20'h5A5A5, 20'hE1F2C},
      '{2'b10, 2'b10, 2'b01, 1'b1, 20'h96E3B, 20'h4D7C2, 20'h7F00F, 20'hC0FFE},
      '{2'b10, 2'b11, 2'b11, 1'b0, 20'hB1E55, 20'h2F6A9, 20'h3C3C3, 20'hA9876},
      '{2'b01, 2'b10, 2'b01, 1'b1, 20'h5D00F, 20'hE7A3C, 20'hD00DF, 20'h24681},
      '{2'b01, 2'b00, 2'b11, 1'b0, 20'h1C0DE, 20'h0FACE, 20'hBEEF1, 20'h80001}
   };

   logic        clk = 0, rst_n = 0;
   logic [1:0]  sync_mode = 2'b11, in_fmt = 0, out_fmt = 0;
   logic        left_is_high = 1, bck_in = 1, lrck_in = 0, sd_drv = 0, loop_en = 0;
   logic [19:0] tx_left = 0, tx_right = 0;
   logic        bck_out, lrck_out, sd_out, tx_load, rx_valid, sd_in;
   logic [19:0] rx_left, rx_right;

   int          n_chk = 0, n_fail = 0, vcnt = 0, lcnt = 0;
   logic [19:0] got_l = 0, got_r = 0;
   int          pt_bad = 0;

   always #5 clk = ~clk;

   assign sd_in = loop_en ? sd_out : sd_drv;

   serial_audio_port i_serial_audio_port (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .in_fmt(in_fmt),
      .out_fmt(out_fmt), .left_is_high(left_is_high), .bck_in(bck_in),
      .lrck_in(lrck_in), .sd_in(sd_in), .tx_left(tx_left), .tx_right(tx_right),
      .bck_out(bck_out), .lrck_out(lrck_out), .sd_out(sd_out), .tx_load(tx_load),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
   );

   always @(posedge clk) begin
      if (rst_n && rx_valid) begin
         got_l <= rx_left;
         got_r <= rx_right;
         vcnt  <= vcnt + 1;
      end
      if (rst_n && tx_load) lcnt <= lcnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic bit_at(input logic [31:0] v, input int idx);
      logic [31:0] t;
      t = v >> idx;
      return t[0];
   endfunction

   function automatic int slot_len(input logic [1:0] m);
      return (m == 2'b01) ? 16 : (m == 2'b10) ? 24 : 32;
   endfunction

   // receive layout from R1..R3
   function automatic int rx_n(input logic [1:0] m, input logic [1:0] f);
      if (m == 2'b01) return 16;
      return (f == 2'b00) ? 16 : (f == 2'b01) ? 18 : 20;
   endfunction
   function automatic logic rx_i2s(input logic [1:0] m, input logic [1:0] f);
      return (f == 2'b11) && (m == 2'b11 || m == 2'b00);
   endfunction

   function automatic logic in_bit(input logic [19:0] raw, input int p, input int n,
                                   input logic i2s, input int j);
      if (i2s) return (j >= 1 && j <= 20) ? bit_at(32'(raw), 20 - j) : 1'b0;
      return (j >= p - n) ? bit_at(32'(raw), p - 1 - j) : 1'b0;
   endfunction

   function automatic logic [19:0] rx_exp(input logic [19:0] raw, input int n);
      logic [31:0] mk;
      mk = (32'd1 << n) - 32'd1;
      return 20'((32'(raw) & mk) << (20 - n));
   endfunction

   // transmit layout from R6..R8
   function automatic logic [31:0] tx_exp(input logic [19:0] w, input logic [1:0] m,
                                          input logic [1:0] f);
      logic [31:0] r;
      int p, n, first;
      p = slot_len(m);
      n = (f[0] && m != 2'b01) ? 20 : 16;
      first = f[1] ? 1 : p - n;
      r = '0;
      for (int j = 0; j < p; j++)
         if (j >= first && j < first + n) r[j] = bit_at(32'(w), 19 - (j - first));
      return r;
   endfunction

   task automatic do_reset(input vec_t v);
      rst_n = 0;
      sync_mode = v.m; in_fmt = v.fi; out_fmt = v.fo; left_is_high = v.pol;
      tx_left = v.tl; tx_right = v.tr;
      bck_in = 1; lrck_in = ~v.pol; sd_drv = 0;
      repeat (4) @(negedge clk);
      rst_n = 1;
      repeat (6) @(negedge clk);
   endtask

   task automatic run_frame(input vec_t v, output logic [31:0] capl, output logic [31:0] capr);
      int p, n;
      logic i2s, lr;
      p = slot_len(v.m);
      n = rx_n(v.m, v.fi);
      i2s = rx_i2s(v.m, v.fi);
      capl = '0; capr = '0;
      for (int ch = 0; ch < 2; ch++) begin
         lr = (ch == 0) ? v.pol : ~v.pol;
         for (int j = 0; j < p; j++) begin
            @(negedge clk);
            bck_in = 0; lrck_in = lr;
            sd_drv = in_bit((ch == 0) ? v.il : v.ir, p, n, i2s, j);
            repeat (4) @(negedge clk);
            if (bck_out !== 1'b0 || lrck_out !== lr) pt_bad++;
            if (ch == 0) capl[j] = sd_out; else capr[j] = sd_out;
            bck_in = 1;
            repeat (3) @(negedge clk);
            if (bck_out !== 1'b1) pt_bad++;
         end
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] cl, cr, dl, dr;
      int v0, l0, n, r;
      logic lv, pb;

      // reset state
      do_reset(VECS[0]);
      rst_n = 0;
      @(negedge clk);
      chk("R5 rx_valid in reset", 32'(rx_valid), 0);
      chk("R5 rx_left in reset", 32'(rx_left), 0);
      chk("R9 tx_load in reset", 32'(tx_load), 0);
      chk("R10 sd_out in reset", 32'(sd_out), 0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         do_reset(VECS[k]);
         v0 = vcnt; l0 = lcnt; pt_bad = 0;
         run_frame(VECS[k], cl, cr);
         chk($sformatf("R9 vec%0d loads after first frame", k), 32'(lcnt - l0), 1);
         chk($sformatf("R6 R7 R8 R4 vec%0d tx left slot", k), cl, tx_exp(VECS[k].tl, VECS[k].m, VECS[k].fo));
         chk($sformatf("R6 R7 R8 R4 vec%0d tx right slot", k), cr, tx_exp(VECS[k].tr, VECS[k].m, VECS[k].fo));
         run_frame(VECS[k], dl, dr);
         n = rx_n(VECS[k].m, VECS[k].fi);
         if (rx_i2s(VECS[k].m, VECS[k].fi)) n = 20;
         chk($sformatf("R5 vec%0d one strobe per pair", k), 32'(vcnt - v0), 1);
         chk($sformatf("R1 R2 R3 R4 vec%0d rx left", k), 32'(got_l), 32'(rx_exp(VECS[k].il, n)));
         chk($sformatf("R1 R2 R3 R4 vec%0d rx right", k), 32'(got_r), 32'(rx_exp(VECS[k].ir, n)));
         chk($sformatf("R5 vec%0d rx_left held", k), 32'(rx_left), 32'(got_l));
         chk($sformatf("R11 vec%0d clock pass-through errors", k), 32'(pt_bad), 0);
      end

      // internal timing, loopback I2S-style 20 bit
      do_reset('{2'b00, 2'b11, 2'b11, 1'b0, 20'h0, 20'h0, 20'hA5C3F, 20'h1234B});
      chk("R12 left slot first after reset", 32'(lrck_out), 0);
      loop_en = 1;
      v0 = vcnt;
      n = 0;
      while (bck_out !== 1'b0) @(negedge clk);
      while (bck_out !== 1'b1) @(negedge clk);
      while (bck_out !== 1'b0) begin @(negedge clk); n++; end
      while (bck_out !== 1'b1) begin @(negedge clk); n++; end
      chk("R12 bit clock period", 32'(n), 8);
      lv = lrck_out;
      while (lrck_out === lv) @(negedge clk);
      lv = lrck_out; pb = bck_out; r = 0;
      while (lrck_out === lv) begin
         @(negedge clk);
         if (bck_out === 1'b1 && pb === 1'b0) r++;
         pb = bck_out;
      end
      chk("R12 bit clocks per channel level", 32'(r), 32);
      repeat (3200) @(negedge clk);
      chk("R2 R12 loopback strobes", 32'(vcnt - v0 >= 3), 1);
      chk("R2 R7 loopback left", 32'(got_l), 32'h0A5C3F);
      chk("R2 R7 loopback right", 32'(got_r), 32'h01234B);

      // internal timing, loopback right-justified 20 bit
      loop_en = 0;
      do_reset('{2'b00, 2'b10, 2'b01, 1'b1, 20'h0, 20'h0, 20'h6E1D9, 20'hF0A35});
      loop_en = 1;
      repeat (3600) @(negedge clk);
      chk("R1 R6 loopback left", 32'(got_l), 32'h06E1D9);
      chk("R1 R6 loopback right", 32'(got_r), 32'h0F0A35);
      loop_en = 0;

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule